// File: doc/BRIEF.md
# Seed Byte Loader and Share Sequencer

This block is the control front end of a masked pseudo-random generator. While the enable input is high it takes one seed byte per clock from an 8-bit input and stores it in a five-lane, 40-bit buffer, filling the lanes in the order the bytes arrive. The first three lanes go to the masked datapath as data shares and the last two as randomness bytes. The datapath itself is outside this block and connects through the share, randomness, start and result ports.

When enable drops, the block pulses a start strobe to the datapath. After a fixed number of cycles it captures the datapath's three result bytes and raises a ready flag on bit 0 of an 8-bit control output. While ready is high, the captured results appear one at a time on the 8-bit data output, cycling in share order. A new rising edge of enable clears ready and starts a new load.

Top module: `seedld_top`

## Requirements
- R1: While reset is held and on the first cycle after it, `ctl_out` is 0x00, `dout` is 0x00 and `dp_start` is low; `dout` is 0x00 whenever ready is low.
- R2: With `en` high, one `din` byte is taken per clock. The k-th byte of a load (k = 0..4) goes to lane k. Lanes 0, 1 and 2 appear on `dp_share` bits [8k+7:8k]. Lane 3 appears on `dp_rand[7:0]` and lane 4 on `dp_rand[15:8]`.
- R3: Bytes that arrive after the fifth one in the same load leave every lane unchanged.
- R4: The first clock edge that samples `en` low after it was high starts the computation: `dp_start` is high for exactly the one cycle that follows that edge.
- R5: Ready rises at the second clock edge after the edge that samples `en` low (CALC_CYC = 2). At that edge `res_in` is captured, with share k taken from bits [8k+7:8k].
- R6: The ready flag is driven on `ctl_out[0]`, and `ctl_out[7:1]` is always zero.
- R7: From the first ready cycle, `dout` shows captured share 0, then 1, then 2 on consecutive cycles, and then starts again at share 0.
- R8: Until the next rising edge of `en`, ready stays high and the captured shares stay as they were. Changes on `res_in` have no effect, and neither do changes on `din` while `en` is low.
- R9: A clock edge that samples `en` high after it was low clears ready, so `dout` returns to 0x00. The byte sampled at that edge becomes lane 0 of a new load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Load enable; its falling edge ends loading |
| din | input | 8 | Seed byte input |
| dout | output | 8 | Captured result share selected by the presentation counter |
| ctl_out | output | 8 | Bit 0 is ready, other bits zero |
| dp_share | output | 24 | Lanes 0..2 as data shares to the datapath |
| dp_rand | output | 16 | Lanes 3..4 as randomness bytes to the datapath |
| dp_start | output | 1 | One-cycle launch strobe to the datapath |
| res_in | input | 24 | Result shares from the datapath |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, five lanes, three shares and a two-cycle compute window. With these values a seven-byte burst goes past the buffer's capacity, and a three-step output selector wraps after a short wait. The bench also reaches a restart that lands while ready is high, followed by a launch from a load that ended early after a single byte.

// File: rtl/seedld_pkg.sv
// Shared types for the seed loader.
// Assumes: nothing beyond a two-bit phase encoding.
package seedld_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_CALC = 2'd2,
        PH_DONE = 2'd3
    } phase_t;
endpackage

// File: rtl/seedld_edge.sv
// Registers the enable input and reports its rising and falling edges.
// Assumes: en is synchronous to clk.
module seedld_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic rise,
    output logic fall
);
    logic en_q;

    // Keep the previous sampled level of enable.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en;
    end

    assign rise = en & ~en_q;
    assign fall = ~en & en_q;
endmodule

// File: rtl/seedld_buffer.sv
// Lane buffer: writes one byte per cycle into consecutive lanes, then stops.
// Assumes: 'first' and 'more' come from the sequencer; 'first' wins.
module seedld_buffer #(
    parameter int BYTE_W  = 8,
    parameter int N_BYTES = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      first,
    input  logic                      more,
    input  logic [BYTE_W-1:0]         din,
    output logic [N_BYTES*BYTE_W-1:0] lanes
);
    localparam int CNT_W = $clog2(N_BYTES + 1);

    logic [CNT_W-1:0]  fill;
    logic [BYTE_W-1:0] lane_q [N_BYTES];
    logic              room;

    assign room = (fill < CNT_W'(N_BYTES));

    // Track how many lanes the current load has filled.
    always_ff @(posedge clk) begin
        if (!rst_n)             fill <= '0;
        else if (first)         fill <= CNT_W'(1);
        else if (more && room)  fill <= fill + CNT_W'(1);
    end

    for (genvar i = 0; i < N_BYTES; i++) begin : g_lane
        logic wr;
        assign wr = (i == 0) ? first : (!first && more && fill == CNT_W'(i));

        // Store the byte for this lane when its turn comes.
        always_ff @(posedge clk) begin
            if (!rst_n)  lane_q[i] <= '0;
            else if (wr) lane_q[i] <= din;
        end

        assign lanes[i*BYTE_W +: BYTE_W] = lane_q[i];
    end
endmodule

// File: rtl/seedld_seq.sv
// Phase sequencer: idle, load, fixed-length compute window, done.
// Assumes: CALC_CYC >= 1; a rising edge of enable restarts from any phase.
module seedld_seq
    import seedld_pkg::*;
#(
    parameter int CALC_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic fall,
    output logic start,
    output logic done,
    output logic ready,
    output logic loading
);
    localparam int CNT_W = (CALC_CYC < 2) ? 1 : $clog2(CALC_CYC);

    phase_t           phase;
    logic [CNT_W-1:0] cnt;
    logic             last;

    assign last = (cnt == CNT_W'(CALC_CYC - 1));

    // Advance the phase and count the compute window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (rise) begin
            phase <= PH_LOAD;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_LOAD: if (fall) begin
                    phase <= PH_CALC;
                    cnt   <= '0;
                end
                PH_CALC: if (last) phase <= PH_DONE;
                         else      cnt   <= cnt + CNT_W'(1);
                default: ;
            endcase
        end
    end

    assign start   = (phase == PH_CALC) && (cnt == '0);
    assign done    = (phase == PH_CALC) && last && !rise;
    assign ready   = (phase == PH_DONE);
    assign loading = (phase == PH_LOAD);
endmodule

// File: rtl/seedld_present.sv
// Captures the result shares and steps through them on the byte output.
// Assumes: 'capture' pulses at the edge where ready rises.
module seedld_present #(
    parameter int BYTE_W   = 8,
    parameter int N_SHARES = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       capture,
    input  logic                       ready,
    input  logic [N_SHARES*BYTE_W-1:0] res_in,
    output logic [BYTE_W-1:0]          dout
);
    localparam int SEL_W = (N_SHARES < 2) ? 1 : $clog2(N_SHARES);

    logic [BYTE_W-1:0] res_q [N_SHARES];
    logic [SEL_W-1:0]  sel;

    for (genvar i = 0; i < N_SHARES; i++) begin : g_cap
        // Latch this result share when the compute window closes.
        always_ff @(posedge clk) begin
            if (!rst_n)       res_q[i] <= '0;
            else if (capture) res_q[i] <= res_in[i*BYTE_W +: BYTE_W];
        end
    end

    // Step the share selector while ready, wrapping after the last share.
    always_ff @(posedge clk) begin
        if (!rst_n || capture) sel <= '0;
        else if (ready)        sel <= (sel == SEL_W'(N_SHARES - 1)) ? '0 : sel + SEL_W'(1);
    end

    // Drive the selected share, or zero when not ready.
    always_comb begin
        dout = '0;
        for (int i = 0; i < N_SHARES; i++)
            if (ready && sel == SEL_W'(i)) dout = res_q[i];
    end
endmodule

// File: rtl/seedld_top.sv
// Seed loader top: edge detect, lane buffer, phase sequencer, share output.
// Assumes: the datapath result on res_in is valid CALC_CYC cycles after the
// edge that ends loading; N_BYTES > N_SHARES.
module seedld_top #(
    parameter int BYTE_W   = 8,
    parameter int N_BYTES  = 5,
    parameter int N_SHARES = 3,
    parameter int CALC_CYC = 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 en,
    input  logic [BYTE_W-1:0]                    din,
    output logic [BYTE_W-1:0]                    dout,
    output logic [BYTE_W-1:0]                    ctl_out,
    output logic [N_SHARES*BYTE_W-1:0]           dp_share,
    output logic [(N_BYTES-N_SHARES)*BYTE_W-1:0] dp_rand,
    output logic                                 dp_start,
    input  logic [N_SHARES*BYTE_W-1:0]           res_in
);
    localparam int BUF_W   = N_BYTES * BYTE_W;
    localparam int SHARE_W = N_SHARES * BYTE_W;

    logic             rise, fall, done, ready, loading;
    logic [BUF_W-1:0] lanes;

    seedld_edge u_edge (
        .clk(clk), .rst_n(rst_n), .en(en), .rise(rise), .fall(fall)
    );

    seedld_seq #(.CALC_CYC(CALC_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
        .start(dp_start), .done(done), .ready(ready), .loading(loading)
    );

    seedld_buffer #(.BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) u_buf (
        .clk(clk), .rst_n(rst_n), .first(rise), .more(loading && en),
        .din(din), .lanes(lanes)
    );

    seedld_present #(.BYTE_W(BYTE_W), .N_SHARES(N_SHARES)) u_pres (
        .clk(clk), .rst_n(rst_n), .capture(done), .ready(ready),
        .res_in(res_in), .dout(dout)
    );

    assign dp_share = lanes[SHARE_W-1:0];
    assign dp_rand  = lanes[BUF_W-1:SHARE_W];
    assign ctl_out  = {{(BYTE_W-1){1'b0}}, ready};
endmodule

// File: rtl/seedld_chk.sv
// Checker for seedld_top, attached by bind. Watches ports only.
// Assumes: synchronous active-low reset on rst_n.
module seedld_chk #(
    parameter int BYTE_W   = 8,
    parameter int N_BYTES  = 5,
    parameter int N_SHARES = 3
) (
    input logic                                 clk,
    input logic                                 rst_n,
    input logic                                 en,
    input logic [BYTE_W-1:0]                    dout,
    input logic [BYTE_W-1:0]                    ctl_out,
    input logic [N_SHARES*BYTE_W-1:0]           dp_share,
    input logic [(N_BYTES-N_SHARES)*BYTE_W-1:0] dp_rand,
    input logic                                 dp_start
);
    logic armed;

    // Mark that the previous edge was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    AST_IDLE_OUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_out[0] |-> (dout == '0));                                          // R1
    AST_START_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(en) && !en) |=> dp_start);                              // R4
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        dp_start |=> !dp_start);                                                // R4
    AST_READY_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_start && !en) ##1 !en |=> ctl_out[0]);                              // R5
    AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_out[0] && !en) |=> ctl_out[0]);                                    // R8
    AST_LANES_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_out[0] && !en) |=> ($stable(dp_share) && $stable(dp_rand)));       // R8
    AST_RISE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && en && !$past(en)) |=> !ctl_out[0]);                           // R9
endmodule

bind seedld_top seedld_chk #(
    .BYTE_W(BYTE_W), .N_BYTES(N_BYTES), .N_SHARES(N_SHARES)
) chk_i (
    .clk(clk), .rst_n(rst_n), .en(en), .dout(dout), .ctl_out(ctl_out),
    .dp_share(dp_share), .dp_rand(dp_rand), .dp_start(dp_start)
);

// File: tb/seedld_top_tb.sv
// Directed bench for seedld_top: one task per scenario.
module seedld_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [7:0]  din = '0;
    logic [7:0]  dout, ctl_out;
    logic [23:0] dp_share, res_in = '0;
    logic [15:0] dp_rand;
    logic        dp_start;

    int checks = 0;
    int errors = 0;
    bit ended  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seedld_top dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .din(din), .dout(dout),
        .ctl_out(ctl_out), .dp_share(dp_share), .dp_rand(dp_rand),
        .dp_start(dp_start), .res_in(res_in)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Feed n bytes base + 17*i with enable high, then drop enable.
    task automatic feed(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); en = 1'b1; din = base + 8'(i * 17);
        end
        @(negedge clk); en = 1'b0; din = 8'hEE;
    endtask

    // Walk the compute window and the first ready cycle.
    task automatic expect_launch(input string tag, input logic [7:0] first_share);
        @(negedge clk);
        chk({tag, " R4 start"}, 32'(dp_start), 32'd1);
        chk({tag, " R5 not ready yet"}, 32'(ctl_out[0]), 32'd0);
        @(negedge clk);
        chk({tag, " R4 start one cycle"}, 32'(dp_start), 32'd0);
        chk({tag, " R5 not ready yet"}, 32'(ctl_out[0]), 32'd0);
        @(negedge clk);
        chk({tag, " R6 ctl_out ready"}, 32'(ctl_out), 32'h01);
        chk({tag, " R7 share0"}, 32'(dout), 32'(first_share));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 ctl_out in reset", 32'(ctl_out), 32'h0);
        chk("R1 dout in reset", 32'(dout), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 start after reset", 32'(dp_start), 32'd0);
        chk("R1 dout after reset", 32'(dout), 32'h0);
    endtask

    task automatic t_basic();
        res_in = 24'hC3B2A1;
        feed(5, 8'h10);
        chk("R2 shares", 32'(dp_share), 32'h322110);
        chk("R2 randomness", 32'(dp_rand), 32'h5443);
        expect_launch("basic", 8'hA1);
        @(negedge clk); chk("R7 share1", 32'(dout), 32'hB2);
        @(negedge clk); chk("R7 share2", 32'(dout), 32'hC3);
        @(negedge clk); chk("R7 wrap share0", 32'(dout), 32'hA1);
    endtask

    task automatic t_hold();
        logic [7:0] exp_s [3];
        exp_s[0] = 8'hA1; exp_s[1] = 8'hB2; exp_s[2] = 8'hC3;
        res_in = 24'hFFFFFF;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk); din = 8'(k * 29);
            chk("R8 ready held", 32'(ctl_out[0]), 32'd1);
            chk("R8 captured share", 32'(dout), 32'(exp_s[k % 3]));
        end
        chk("R8 lanes untouched", 32'(dp_share), 32'h322110);
    endtask

    task automatic t_overflow();
        res_in = 24'h334455;
        feed(7, 8'h80);
        chk("R3 shares", 32'(dp_share), 32'hA29180);
        chk("R3 randomness", 32'(dp_rand), 32'hC4B3);
        expect_launch("overflow", 8'h55);
    endtask

    task automatic t_restart();
        res_in = 24'h0F0E0D;
        @(negedge clk); en = 1'b1; din = 8'h5A;
        @(negedge clk);
        chk("R9 ready cleared", 32'(ctl_out[0]), 32'd0);
        chk("R9 dout zero", 32'(dout), 32'h0);
        chk("R9 new lane0", 32'(dp_share[7:0]), 32'h5A);
        en = 1'b0;
        expect_launch("restart", 8'h0D);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_hold();
        t_overflow();
        t_restart();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end
endmodule